// File: doc/BRIEF.md
# Serial Converter Output Frame Engine

This block is the digital half of a serial successive-approximation converter. It runs entirely in the system clock domain. The active-low chip select and the serial clock arrive from an external controller and are resynchronised. Their falling edges are then found on the synchronised levels. When chip select falls, the block captures a parallel sample word from a stimulus port. It then shifts out a sixteen-slot frame: two leading zero slots followed by the fourteen sample bits, most significant bit first. Each bit is presented after the serial clock falling edge that owns it.

The clock level at the moment chip select falls decides how the frame begins. If the clock is high, the block arms and waits for the next clock fall. If the clock is low, or it falls together with chip select, the chip select fall itself counts as the first falling edge. A conversion/acquisition flag is high while the frame is being converted. The flag drops on the sixteenth falling edge, and it also drops whenever chip select is released. The output enable follows chip select, so releasing chip select early aborts the frame. A fresh frame then starts only on the next chip select fall.

Top module: `ser_frame_engine`

## Requirements
- R1: Out of reset and whenever chip select is high, the output enable is 0, the mode flag is 0 (acquisition) and the data output is 0.
- R2: The output enable rises after a chip select fall and drops after a chip select rise.
- R3: If chip select falls while the serial clock is high, the block waits with enable 1, mode 0 and data 0. The next serial clock fall is counted as falling edge 1.
- R4: If chip select falls while the serial clock is low, the chip select fall counts as falling edge 1, and the mode flag goes high without any clock edge.
- R5: If chip select and the serial clock fall in the same cycle, the fall counts as edge 1 at once.
- R6: After falling edges 1 and 2 the data output is 0. After falling edge k, for k from 3 to 16, it carries sample bit 16-k, so bit 13 comes first and bit 0 comes last.
- R7: The sample word is captured at the chip select fall. Changes on the sample port later in the frame do not alter the bits shifted out.
- R8: The mode flag is 1 after falling edges 1 to 15 and drops to 0 on the 16th falling edge.
- R9: A chip select rise before the 16th falling edge aborts the frame, with enable 0 and mode 0. Serial clock edges while chip select is high change nothing. The next frame restarts at falling edge 1 with a newly captured sample.
- R10: After the 16th falling edge, with chip select still low, further serial clock edges are ignored. The data output holds bit 0 and the mode flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least eight times the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sample_i | input | 14 | Parallel sample word, two's complement |
| sdo_o | output | 1 | Serial data output, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable (high means driven) |
| conv_mode_o | output | 1 | 1 in conversion mode, 0 in acquisition mode |

## Verification
A wrong falling-edge count shows up as a misplaced bit on the data output at the next sample point, half a serial clock after the edge. It can also show up as a mode flag that drops one edge early or late. A wrong entry decision shifts the whole frame by one slot, so every data bit from edge 3 onward miscompares. An abort that leaves state behind is exposed in the following frame: its first bits or its mode flag differ from a clean start. A bad capture point shows because the sample port is changed mid-frame, and the later bits then follow the new word instead of the captured one.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_ARMED = 2'd1,
      FS_SHIFT = 2'd2,
      FS_DONE  = 2'd3
   } frame_state_e;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int W = 2,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sfe_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/sfe_fall_det.sv
module sfe_fall_det #(
   parameter int W = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   assign fall = prev & ~lvl;
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
   import sfe_pkg::*;
#(
   parameter int FRAME_LEN = 16,
   localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_lvl,
   input  logic             sck_lvl,
   input  logic             cs_fall,
   input  logic             sck_fall,
   output logic             load,
   output logic             step,
   output logic [CNT_W-1:0] fall_cnt,
   output logic             frame_on,
   output logic             converting
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   if (FRAME_LEN < 2) begin : g_bad_len
      $error("sfe_ctrl: FRAME_LEN must be at least 2");
   end

   frame_state_e     st;
   logic [CNT_W-1:0] cnt;
   logic             first_now;
   logic             clk_step;

   assign first_now = cs_fall & ~sck_lvl;
   assign clk_step  = sck_fall & ~cs_lvl & ((st == FS_ARMED) | (st == FS_SHIFT));
   assign load      = cs_fall;
   assign step      = first_now | (~cs_fall & clk_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= FS_IDLE;
         cnt <= '0;
      end else if (cs_lvl) begin
         st  <= FS_IDLE;
         cnt <= '0;
      end else if (cs_fall) begin
         if (first_now) begin
            st  <= FS_SHIFT;
            cnt <= ONE;
         end else begin
            st  <= FS_ARMED;
            cnt <= '0;
         end
      end else if (clk_step) begin
         cnt <= cnt + ONE;
         st  <= (cnt + ONE == LAST) ? FS_DONE : FS_SHIFT;
      end
   end

   assign fall_cnt   = cnt;
   assign frame_on   = (st != FS_IDLE);
   assign converting = (st == FS_SHIFT);
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
   parameter int DATA_W = 14,
   parameter int LEAD_ZEROS = 2,
   localparam int FRAME_LEN = DATA_W + LEAD_ZEROS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              step,
   input  logic [DATA_W-1:0] sample,
   output logic              bit_o
);
   logic [FRAME_LEN-1:0] frame_word;
   logic [FRAME_LEN-1:0] sh;
   logic                 bit_r;

   if (LEAD_ZEROS > 0) begin : g_lead
      assign frame_word = {{LEAD_ZEROS{1'b0}}, sample};
   end else begin : g_nolead
      assign frame_word = sample;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         bit_r <= 1'b0;
      end else if (clr) begin
         sh    <= '0;
         bit_r <= 1'b0;
      end else if (load) begin
         if (step) begin
            bit_r <= frame_word[FRAME_LEN-1];
            sh    <= frame_word << 1;
         end else begin
            bit_r <= 1'b0;
            sh    <= frame_word;
         end
      end else if (step) begin
         bit_r <= sh[FRAME_LEN-1];
         sh    <= sh << 1;
      end
   end

   assign bit_o = bit_r;
endmodule

// File: rtl/ser_frame_engine.sv
module ser_frame_engine #(
   parameter int DATA_W = 14,
   parameter int LEAD_ZEROS = 2,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_LEN = DATA_W + LEAD_ZEROS,
   localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic              conv_mode_o
);
   localparam logic [1:0] IDLE_LVL = 2'b10;

   if (DATA_W < 1) begin : g_bad_width
      $error("ser_frame_engine: DATA_W must be positive");
   end

   logic [1:0]       lvl_s;
   logic [1:0]       fall_s;
   logic             cs_sync;
   logic             sck_sync;
   logic             load;
   logic             step;
   logic             frame_on;
   logic             converting;
   logic             sdo_bit;
   logic [CNT_W-1:0] fall_cnt;

   sfe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk}), .q(lvl_s));

   assign cs_sync  = lvl_s[1];
   assign sck_sync = lvl_s[0];

   sfe_fall_det #(.W(2), .RST_VAL(IDLE_LVL)) u_fall (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .fall(fall_s));

   sfe_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_lvl(cs_sync), .sck_lvl(sck_sync),
      .cs_fall(fall_s[1]), .sck_fall(fall_s[0]),
      .load(load), .step(step), .fall_cnt(fall_cnt),
      .frame_on(frame_on), .converting(converting));

   sfe_shifter #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(cs_sync),
      .load(load), .step(step), .sample(sample_i), .bit_o(sdo_bit));

   assign sdo_oe_o    = frame_on;
   assign conv_mode_o = converting;
   assign sdo_o       = frame_on & sdo_bit;
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
   parameter int FRAME_LEN = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_lvl,
   input logic             sck_lvl,
   input logic [CNT_W-1:0] cnt,
   input logic             sdo_o,
   input logic             sdo_oe_o,
   input logic             conv_mode_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> (!sdo_o && !conv_mode_o));

   // R2
   oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_lvl) |=> !sdo_oe_o);

   // R2
   oe_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_lvl) |=> sdo_oe_o);

   // R3
   armed_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_lvl) && sck_lvl) |=> !conv_mode_o);

   // R4
   low_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_lvl) && !sck_lvl) |=> conv_mode_o);

   // R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

   // R8
   mode_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_mode_o |-> sdo_oe_o);

   // R8
   acq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LAST) |-> !conv_mode_o);

   // R10
   tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LAST && $past(cnt) == LAST) |-> $stable(sdo_o));
endmodule

bind ser_frame_engine sfe_checker #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_lvl(cs_sync), .sck_lvl(sck_sync),
   .cnt(fall_cnt), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .conv_mode_o(conv_mode_o));

// File: tb/ser_frame_engine_test.sv
module ser_frame_engine_test;
   localparam int DW = 14;
   localparam int FL = 16;
   localparam int HALF = 8;

   typedef struct {
      logic  sdo;
      logic  oe;
      logic  mode;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          sclk = 1'b0;
   logic [DW-1:0] sample_i = '0;
   logic          sdo_o, sdo_oe_o, conv_mode_o;

   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 1'b0;
   exp_t expq[$];
   event chk_ev;

   always #2.5 clk = ~clk;

   ser_frame_engine uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .sample_i(sample_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
      .conv_mode_o(conv_mode_o));

   // Monitor: pops one expected item per trigger and compares at the ports
   initial begin
      forever begin
         @(chk_ev);
         while (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            vectors++;
            if (sdo_o !== e.sdo || sdo_oe_o !== e.oe || conv_mode_o !== e.mode) begin
               miscompares++;
               $display("FAIL %s: got sdo=%b oe=%b mode=%b, expected sdo=%b oe=%b mode=%b",
                        e.tag, sdo_o, sdo_oe_o, conv_mode_o, e.sdo, e.oe, e.mode);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_now(input logic s, input logic oe, input logic m, input string tag);
      exp_t e;
      e.sdo = s; e.oe = oe; e.mode = m; e.tag = tag;
      expq.push_back(e);
      ->chk_ev;
      #0.1;
   endtask

   // entry: 0 = clock high at select fall (R3), 1 = clock low (R4), 2 = together (R5)
   task automatic run_frame(input int entry, input logic [DW-1:0] data, input int stop_at,
                            input string tag);
      if (entry == 1) begin
         sclk = 1'b0; tick(HALF);
         sample_i = data; cs_n = 1'b0; tick(HALF);
      end else begin
         sclk = 1'b1; tick(HALF);
         sample_i = data;
         if (entry == 2) begin
            cs_n = 1'b0; sclk = 1'b0; tick(HALF);
         end else begin
            cs_n = 1'b0; tick(HALF);
            expect_now(1'b0, 1'b1, 1'b0, {tag, " R3 armed wait"});
            sclk = 1'b1; tick(2);
            expect_now(1'b0, 1'b1, 1'b0, {tag, " R3 still armed"});
            sclk = 1'b0; tick(HALF);
         end
      end
      for (int k = 1; k <= FL; k++) begin
         logic eb;
         eb = (k <= 2) ? 1'b0 : data[FL - k];
         expect_now(eb, 1'b1, (k < FL) ? 1'b1 : 1'b0,
                    $sformatf("%s R6 R8 edge %0d", tag, k));
         if (k == 5) sample_i = ~data;  // R7: late change must not leak into the frame
         if (k == stop_at) break;
         sclk = 1'b1; tick(HALF);
         sclk = 1'b0; tick(HALF);
      end
      if (stop_at < FL) begin
         cs_n = 1'b1; tick(6);
         expect_now(1'b0, 1'b0, 1'b0, {tag, " R9 abort"});
         for (int i = 0; i < 2; i++) begin
            sclk = 1'b1; tick(HALF);
            sclk = 1'b0; tick(HALF);
         end
         expect_now(1'b0, 1'b0, 1'b0, {tag, " R9 clock ignored while deselected"});
      end else begin
         for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; tick(HALF);
            sclk = 1'b0; tick(HALF);
            expect_now(data[0], 1'b1, 1'b0, {tag, " R10 tail hold"});
         end
         cs_n = 1'b1; tick(6);
         expect_now(1'b0, 1'b0, 1'b0, {tag, " R2 R1 release"});
      end
   endtask

   initial begin
      tick(4);
      expect_now(1'b0, 1'b0, 1'b0, "R1 in reset");
      rst_n = 1'b1; tick(6);
      expect_now(1'b0, 1'b0, 1'b0, "R1 after reset");
      run_frame(0, 14'h2A5C, FL, "F1");
      run_frame(1, 14'h1FFF, FL, "F2");
      run_frame(2, 14'h2000, FL, "F3");
      run_frame(1, 14'h3333, 6, "F4");
      run_frame(0, 14'h0001, FL, "F5 after abort");
      run_frame(2, 14'h15A3, 2, "F6");
      run_frame(1, 14'h2C71, FL, "F7 after early abort");
      tick(4);
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule